// File: doc/BRIEF.md
# Asynchronous Memory Strobe Controller

This block turns single read and write requests from an on-chip master into strobed cycles on an asynchronous external memory bus. Every access passes through three timed phases: setup, strobe and hold. During these phases the block drives a chip select, a read strobe or a write strobe, the address, a bank address, byte enables and write data. For reads it captures the data returned by the memory. Reads and writes each have their own setup, strobe and hold lengths. A configurable idle gap after each access gives a slow device time to release the data bus.

Two options change the strobe. In select-strobe mode the chip select is asserted only during the strobe phase. With wait extension enabled, a slow device can stretch the strobe by holding a wait pin high, for at most sixteen times a programmed count. When that allowance runs out, the strobe ends anyway and a sticky timeout flag is set. The master uses a valid/ready handshake and receives a one-cycle completion pulse. For reads, that pulse comes with the captured data.

Configuration inputs are sampled as the access proceeds and are expected to stay constant while an access is in flight.

Top module: `amem_ctrl`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is 0, `done` and `wait_timeout` are 0, and `req_ready` is 1.
- R2: A read accepted at a clock edge occupies the following RS+RST+RH cycles. The counts come from `cfg_rd_setup`, `cfg_rd_strobe` and `cfg_rd_hold`. `mem_oe_n` is low for exactly the RST cycles that follow the RS setup cycles, and `mem_we_n` stays high.
- R3: A write occupies WS+WST+WH cycles, counted from `cfg_wr_setup`, `cfg_wr_strobe` and `cfg_wr_hold`. `mem_we_n` is low for exactly WST cycles after WS setup cycles, and `mem_oe_n` stays high. The read and write counts are independent of each other.
- R4: A setup, hold or turnaround count of 0 removes that phase. A strobe count of 0 behaves as a count of 1.
- R5: With `cfg_sel_strobe`=0, `mem_cs_n` is low through setup, strobe and hold. With `cfg_sel_strobe`=1, it is low only in the strobe cycles.
- R6: `mem_addr`, `mem_bank` and `mem_be_n` carry the request's address, bank and inverted byte mask (`mem_be_n` = ~`req_mask`) in every cycle of the access.
- R7: On a write, `mem_dq_oe` is 1 and `mem_dq_out` equals `req_wdata` in every setup, strobe and hold cycle. On a read, `mem_dq_oe` stays 0.
- R8: Read data is sampled from `mem_dq_in` at the clock edge that ends the last strobe cycle. `done` is high for exactly one cycle, the cycle after the last access cycle, and `done_rdata` then holds the sampled read data.
- R9: With `cfg_wait_en`=1, if the synchronized `mem_wait` (active high) is high when the programmed strobe count is used up, the strobe continues while it stays high. With `cfg_wait_en`=0, `mem_wait` has no effect.
- R10: `mem_wait` passes through four register stages. If `mem_wait` falls just after clock edge E, the strobe ends at edge E+5 and the strobe pin is high in the cycle that follows. This gives a release delay of 4 to 5 cycles.
- R11: If the synchronized wait is still high once the 16×`cfg_wait_cnt` extension cycles are used up, the strobe ends after RST+16×`cfg_wait_cnt` cycles and `wait_timeout` becomes 1. It stays 1 until reset. A wait that falls exactly at that final cycle ends the strobe without setting the flag.
- R12: After the last access cycle, `cfg_turn` turnaround cycles pass before `req_ready` returns to 1. `done` falls in the first of those cycles.
- R13: `req_ready` is 0 from the cycle after acceptance until the access and its turnaround end. A request is accepted only on an edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rd_setup | input | CW | Read setup cycles |
| cfg_rd_strobe | input | CW | Read strobe cycles (0 counts as 1) |
| cfg_rd_hold | input | CW | Read hold cycles |
| cfg_wr_setup | input | CW | Write setup cycles |
| cfg_wr_strobe | input | CW | Write strobe cycles (0 counts as 1) |
| cfg_wr_hold | input | CW | Write hold cycles |
| cfg_turn | input | CW | Idle cycles after each access |
| cfg_sel_strobe | input | 1 | Chip select only during strobe |
| cfg_wait_en | input | 1 | Allow wait pin to stretch the strobe |
| cfg_wait_cnt | input | EW | Stretch limit in units of 16 cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_bank | input | BW | Request bank address |
| req_mask | input | MW | Byte enables, active high |
| req_wdata | input | DW | Write data |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DW | Captured read data |
| wait_timeout | output | 1 | Sticky: stretch limit reached with wait still high |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | AW | Memory address |
| mem_bank | output | BW | Memory bank address |
| mem_be_n | output | MW | Byte enables, active low |
| mem_dq_out | output | DW | Write data to pads |
| mem_dq_oe | output | 1 | Data pad drive enable |
| mem_dq_in | input | DW | Read data from pads |
| mem_wait | input | 1 | Wait from memory, active high, asynchronous |

## Verification
Two events can decide the end of a stretched strobe in the same cycle: the synchronized wait falling, and the extension allowance reaching zero. The bench provokes this with a 16-cycle allowance. It drops the wait pin so that the synchronized low arrives exactly at the final permitted strobe cycle, and it expects an 18-cycle strobe with no timeout. It then repeats the access with the drop one cycle later and expects the same strobe length with the timeout flag set. The release delay itself is judged on its own by counting strobe cycles after a drop placed well inside the allowance.

// File: rtl/amem_ctrl.sv
module amem_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BW = 2,
  parameter int MW = 2,
  parameter int CW = 4,
  parameter int EW = 4,
  parameter int WAIT_STAGES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_rd_setup,
  input  logic [CW-1:0] cfg_rd_strobe,
  input  logic [CW-1:0] cfg_rd_hold,
  input  logic [CW-1:0] cfg_wr_setup,
  input  logic [CW-1:0] cfg_wr_strobe,
  input  logic [CW-1:0] cfg_wr_hold,
  input  logic [CW-1:0] cfg_turn,
  input  logic          cfg_sel_strobe,
  input  logic          cfg_wait_en,
  input  logic [EW-1:0] cfg_wait_cnt,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_bank,
  input  logic [MW-1:0] req_mask,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] done_rdata,
  output logic          wait_timeout,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_bank,
  output logic [MW-1:0] mem_be_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  input  logic          mem_wait
);
  localparam int XW = EW + 4;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_TURN} st_t;

  st_t                  st;
  logic [CW-1:0]        cnt;
  logic [XW-1:0]        ext;
  logic                 wr_q;
  logic [DW-1:0]        wdata_q;
  logic [MW-1:0]        mask_q;
  logic [WAIT_STAGES-1:0] wsh;

  wire wsync  = wsh[WAIT_STAGES-1];
  wire busy   = (st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD);
  wire accept = req_valid && req_ready;
  wire wr_sel = (st == S_IDLE) ? req_write : wr_q;

  wire [CW-1:0] s_len = wr_sel ? cfg_wr_setup  : cfg_rd_setup;
  wire [CW-1:0] t_len = wr_sel ? cfg_wr_strobe : cfg_rd_strobe;
  wire [CW-1:0] h_len = wr_sel ? cfg_wr_hold   : cfg_rd_hold;
  wire [CW-1:0] t_eff = (t_len == '0) ? CW'(1) : t_len;
  wire [XW-1:0] ext_init = {cfg_wait_cnt, 4'b0000};

  wire base_done  = (st == S_STROBE) && (cnt == '0);
  wire stretch    = cfg_wait_en && wsync && (ext != '0);
  wire strobe_end = base_done && !stretch;
  wire last_cyc   = (strobe_end && h_len == '0) || (st == S_HOLD && cnt == '0);

  assign req_ready  = (st == S_IDLE);
  assign mem_cs_n   = cfg_sel_strobe ? (st != S_STROBE) : !busy;
  assign mem_oe_n   = !((st == S_STROBE) && !wr_q);
  assign mem_we_n   = !((st == S_STROBE) && wr_q);
  assign mem_be_n   = ~mask_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = busy && wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      ext          <= '0;
      wr_q         <= 1'b0;
      mem_addr     <= '0;
      mem_bank     <= '0;
      mask_q       <= '0;
      wdata_q      <= '0;
      done         <= 1'b0;
      done_rdata   <= '0;
      wait_timeout <= 1'b0;
      wsh          <= '0;
    end else begin
      wsh  <= {wsh[WAIT_STAGES-2:0], mem_wait};
      done <= last_cyc;
      if (strobe_end && !wr_q) done_rdata <= mem_dq_in;
      if (strobe_end && cfg_wait_en && wsync) wait_timeout <= 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          wr_q     <= req_write;
          mem_addr <= req_addr;
          mem_bank <= req_bank;
          mask_q   <= req_mask;
          wdata_q  <= req_wdata;
          if (s_len != '0) begin
            st  <= S_SETUP;
            cnt <= s_len - CW'(1);
          end else begin
            st  <= S_STROBE;
            cnt <= t_eff - CW'(1);
            ext <= ext_init;
          end
        end
        S_SETUP: if (cnt == '0) begin
          st  <= S_STROBE;
          cnt <= t_eff - CW'(1);
          ext <= ext_init;
        end else cnt <= cnt - CW'(1);
        S_STROBE: if (cnt != '0) cnt <= cnt - CW'(1);
          else if (stretch) ext <= ext - XW'(1);
          else if (h_len != '0) begin
            st  <= S_HOLD;
            cnt <= h_len - CW'(1);
          end else if (cfg_turn != '0) begin
            st  <= S_TURN;
            cnt <= cfg_turn - CW'(1);
          end else st <= S_IDLE;
        S_HOLD: if (cnt != '0) cnt <= cnt - CW'(1);
          else if (cfg_turn != '0) begin
            st  <= S_TURN;
            cnt <= cfg_turn - CW'(1);
          end else st <= S_IDLE;
        S_TURN: if (cnt != '0) cnt <= cnt - CW'(1);
          else st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe_n || mem_we_n);
  p_cs_with_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);
  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_bank) && $stable(mem_be_n)));
  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_timeout_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wait_timeout |=> wait_timeout);
  p_ready_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_dq_oe));
endmodule

// File: tb/tb_amem_ctrl.sv
module tb_amem_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  cfg_rd_setup = 0, cfg_rd_strobe = 1, cfg_rd_hold = 0;
  logic [3:0]  cfg_wr_setup = 0, cfg_wr_strobe = 1, cfg_wr_hold = 0;
  logic [3:0]  cfg_turn = 0, cfg_wait_cnt = 0;
  logic        cfg_sel_strobe = 0, cfg_wait_en = 0;
  logic        req_valid = 0, req_write = 0, req_ready;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic [1:0]  req_bank = 0, req_mask = 0;
  logic        done, wait_timeout, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] done_rdata, mem_addr, mem_dq_out, mem_dq_in;
  logic [1:0]  mem_bank, mem_be_n;
  logic        mem_wait = 0;
  logic [7:0]  oe_cyc = 0;

  always_ff @(posedge clk) oe_cyc <= mem_oe_n ? 8'd0 : oe_cyc + 8'd1;
  assign mem_dq_in = {mem_addr[7:0], oe_cyc};

  amem_ctrl dut (.*);

  int n_chk = 0, n_bad = 0;
  int cs_cnt, oe_cnt, we_cnt, cs_first, oe_first, we_first, dq_cnt, dq_bad;
  int addr_bad, done_idx, done_cnt, ready_idx, rdy_busy;
  logic [15:0] rdata_got;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_access(input logic wr, input logic [15:0] a, input logic [1:0] b,
                            input logic [1:0] m, input logic [15:0] wd);
    bit done_seen;
    cs_cnt = 0; oe_cnt = 0; we_cnt = 0; cs_first = 0; oe_first = 0; we_first = 0;
    dq_cnt = 0; dq_bad = 0; addr_bad = 0; done_idx = 0; done_cnt = 0;
    ready_idx = 0; rdy_busy = 0; rdata_got = 0; done_seen = 0;
    @(posedge clk); #1;
    req_write = wr; req_addr = a; req_bank = b; req_mask = m; req_wdata = wd; req_valid = 1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1 req_valid = 0;
    for (int i = 1; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin done_cnt++; if (!done_seen) begin done_idx = i; rdata_got = done_rdata; end done_seen = 1; end
      if (!done_seen) begin
        if (req_ready) rdy_busy++;
        if (mem_addr != a || mem_bank != b || mem_be_n != ~m) addr_bad++;
        if (!mem_cs_n) begin cs_cnt++; if (cs_first == 0) cs_first = i; end
        if (!mem_oe_n) begin oe_cnt++; if (oe_first == 0) oe_first = i; end
        if (!mem_we_n) begin we_cnt++; if (we_first == 0) we_first = i; end
        if (mem_dq_oe) begin dq_cnt++; if (mem_dq_out != wd) dq_bad++; end
      end
      if (done_seen && req_ready) begin ready_idx = i; break; end
    end
  endtask

  task automatic drop_wait_after(input int k);
    do @(negedge clk); while (mem_oe_n);
    repeat (k) @(posedge clk);
    #1 mem_wait = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 cs_n", mem_cs_n, 1); chk("R1 oe_n", mem_oe_n, 1); chk("R1 we_n", mem_we_n, 1);
    chk("R1 dq_oe", mem_dq_oe, 0); chk("R1 done", done, 0);
    chk("R1 timeout", wait_timeout, 0); chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_read_basic;
    cfg_rd_setup = 2; cfg_rd_strobe = 3; cfg_rd_hold = 1; cfg_turn = 2;
    cfg_wr_setup = 5; cfg_wr_strobe = 7; cfg_wr_hold = 4;
    run_access(0, 16'h12C4, 2'd2, 2'b01, 16'hFFFF);
    chk("R2 cs cycles", cs_cnt, 6); chk("R2 oe cycles", oe_cnt, 3);
    chk("R2 oe start", oe_first, 3); chk("R2 we idle", we_cnt, 0);
    chk("R6 addr/bank/be", addr_bad, 0); chk("R7 no drive on read", dq_cnt, 0);
    chk("R8 done index", done_idx, 7); chk("R8 done width", done_cnt, 1);
    chk("R8 read data", rdata_got, 16'hC402);
    chk("R12 turnaround", ready_idx - done_idx, 2); chk("R13 busy ready", rdy_busy, 0);
  endtask

  task automatic t_read_zero;
    cfg_rd_setup = 0; cfg_rd_strobe = 0; cfg_rd_hold = 0; cfg_turn = 0;
    run_access(0, 16'h0077, 2'd1, 2'b10, 16'h0);
    chk("R4 cs cycles", cs_cnt, 1); chk("R4 oe cycles", oe_cnt, 1);
    chk("R4 oe start", oe_first, 1); chk("R4 done index", done_idx, 2);
    chk("R8 read data zero", rdata_got, 16'h7700);
    chk("R4 no turnaround", ready_idx - done_idx, 0);
  endtask

  task automatic t_write_basic;
    cfg_wr_setup = 1; cfg_wr_strobe = 4; cfg_wr_hold = 2; cfg_turn = 1;
    cfg_rd_setup = 6; cfg_rd_strobe = 6; cfg_rd_hold = 6;
    run_access(1, 16'hBEEF, 2'd3, 2'b11, 16'h5A3C);
    chk("R3 cs cycles", cs_cnt, 7); chk("R3 we cycles", we_cnt, 4);
    chk("R3 we start", we_first, 2); chk("R3 oe idle", oe_cnt, 0);
    chk("R7 drive cycles", dq_cnt, 7); chk("R7 drive data", dq_bad, 0);
    chk("R6 addr/bank/be", addr_bad, 0); chk("R8 done index", done_idx, 8);
    chk("R12 turnaround", ready_idx - done_idx, 1);
  endtask

  task automatic t_sel_strobe;
    cfg_sel_strobe = 1; cfg_wr_setup = 2; cfg_wr_strobe = 2; cfg_wr_hold = 2; cfg_turn = 0;
    run_access(1, 16'h0400, 2'd0, 2'b01, 16'h1111);
    chk("R5 cs cycles", cs_cnt, 2); chk("R5 cs start", cs_first, 3);
    chk("R5 we start", we_first, 3); chk("R7 drive cycles", dq_cnt, 6);
    cfg_sel_strobe = 0;
  endtask

  task automatic t_wait_off;
    cfg_rd_setup = 1; cfg_rd_strobe = 2; cfg_rd_hold = 1; cfg_wait_en = 0; cfg_wait_cnt = 3;
    mem_wait = 1; repeat (6) @(posedge clk);
    run_access(0, 16'h0101, 2'd0, 2'b11, 16'h0);
    chk("R9 wait ignored", oe_cnt, 2); chk("R9 no timeout", wait_timeout, 0);
    #1 mem_wait = 0;
  endtask

  task automatic t_wait_release;
    cfg_wait_en = 1; cfg_wait_cnt = 15;
    mem_wait = 1; repeat (6) @(posedge clk);
    fork
      run_access(0, 16'h0A0A, 2'd1, 2'b11, 16'h0);
      drop_wait_after(10);
    join
    chk("R10 release delay", oe_cnt, 15); chk("R9 extended read data", rdata_got, 16'h0A0E);
    chk("R10 no timeout", wait_timeout, 0);
  endtask

  task automatic t_coincide;
    cfg_wait_cnt = 1;
    mem_wait = 1; repeat (6) @(posedge clk);
    fork
      run_access(0, 16'h0202, 2'd0, 2'b11, 16'h0);
      drop_wait_after(13);
    join
    chk("R11 coincide strobe", oe_cnt, 18); chk("R11 coincide no timeout", wait_timeout, 0);
  endtask

  task automatic t_timeout;
    cfg_wait_cnt = 1;
    mem_wait = 1; repeat (6) @(posedge clk);
    fork
      run_access(0, 16'h0303, 2'd0, 2'b11, 16'h0);
      drop_wait_after(14);
    join
    chk("R11 limit strobe", oe_cnt, 18); chk("R11 timeout set", wait_timeout, 1);
    cfg_wait_cnt = 2; cfg_wr_setup = 1; cfg_wr_strobe = 2; cfg_wr_hold = 1;
    mem_wait = 1; repeat (6) @(posedge clk);
    run_access(1, 16'h0404, 2'd0, 2'b11, 16'h9999);
    chk("R11 write limit strobe", we_cnt, 34); chk("R11 timeout sticky", wait_timeout, 1);
    #1 mem_wait = 0;
  endtask

  bit finished = 0;
  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_read_basic;
    t_read_zero;
    t_write_basic;
    t_sel_strobe;
    t_wait_off;
    t_wait_release;
    t_coincide;
    t_timeout;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule